// File: doc/BRIEF.md
# Linear Instruction Prefetch Queue

This block sits between an external word-wide instruction memory and the execution unit. It holds a short run of consecutive instruction words in one address window, described by a base address and a fill count. The execution unit asks for a word by presenting its program counter. When the address lies inside the window, the word comes back in the same cycle. When the word is the one memory is returning right now, it is passed through and stored in that same cycle. In every other case the execution unit waits.

The queue fetches ahead of the last requested address on its own, one word at a time, with at most one fetch in flight. A flow-control change is signalled with a redirect strobe next to the request. A target inside the window is served from storage, so short backward loops run with no memory traffic. A target outside the window empties the queue, moves the base to the target and starts filling from there. A fetch that is still in flight at that moment is marked with the old epoch, and its data is thrown away when it returns. Once the window holds its full depth, each new word pushes out the oldest one.

Top module: `insn_prefetch_queue`

## Requirements
- R1: After reset the queue is empty, `ex_valid` is low and the first fetch request presents address 0.
- R2: At most one fetch is outstanding. No new request is raised between a grant and the matching `mem_rvalid`.
- R3: Each word that returns for the current epoch is stored at the next window position. When `ex_req` is high and `ex_addr` equals that word's address, the word is delivered in the same cycle, with `ex_valid` high and `ex_data` equal to `mem_rdata`.
- R4: The queue keeps fetching sequentially while the next fill address is less than AHEAD (default 4) words beyond the last requested address, and then stops. With the execution unit parked at address p after a purge-free run from 0, exactly p+AHEAD words (0 to p+AHEAD-1) are fetched.
- R5: A request to an address in the range [base, base+count) is answered in the same cycle from storage, with no wait.
- R6: A redirect whose target lies inside the window causes no purge. A loop over words already held runs with zero wait cycles and raises no new memory grant.
- R7: A redirect whose target lies outside the window empties the queue and moves the base to the target. The next granted fetch address is the target.
- R8: A fetch granted before a purge has its returned data discarded. It is neither stored nor delivered, and the execution unit receives the word for its new target.
- R9: The window holds at most DEPTH (16) words. When it is full, each new word drops the lowest address and the base advances by one, so the dropped address then misses.
- R10: `ex_valid` is never high without `ex_req`. A request that misses holds `ex_valid` low until its word arrives from memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ex_req | input | 1 | Execution unit requests the word at `ex_addr` |
| ex_redir | input | 1 | The current request is a flow-control target |
| ex_addr | input | AW (16) | Program-counter word address |
| ex_data | output | DW (16) | Instruction word returned to the execution unit |
| ex_valid | output | 1 | `ex_data` holds the requested word this cycle |
| mem_req | output | 1 | Fetch request to memory |
| mem_addr | output | AW (16) | Fetch word address |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Returned word is present on `mem_rdata` |
| mem_rdata | input | DW (16) | Returned instruction word |

## Verification
Every cycle, the embedded properties check the window bookkeeping: the bound on the count, how the count grows on each accepted word, how the base slides once the window is full, the base and count after a purge, the single-fetch rule, and that stale returns never drive `ex_valid`. Only the bench scenarios can show that the data is correct: words delivered both through the pass-through and from storage, how far the fetch-ahead runs, zero-wait loops, the dropped oldest address, and the recovery from an in-flight fetch that a purge cut short. These scenarios are repeated for memory latencies of one to three cycles.

// File: rtl/lpq_pkg.sv
package lpq_pkg;

   // True when v is a power of two no smaller than two.
   function automatic bit lpq_pow2(input int v);
      return (v >= 2) && ((v & (v - 1)) == 0);
   endfunction

   // Width of a fill count able to hold 0..depth.
   function automatic int lpq_cnt_w(input int depth);
      return $clog2(depth) + 1;
   endfunction

endpackage

// File: rtl/lpq_store.sv
module lpq_store #(
   parameter int DW    = 16,
   parameter int DEPTH = 16,
   localparam int IW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [IW-1:0] wr_idx,
   input  logic [DW-1:0] wr_data,
   input  logic [IW-1:0] rd_idx,
   output logic [DW-1:0] rd_data
);

   logic [DW-1:0] words [DEPTH];

   // One register per slot; a slot is addressed by the low bits of the word address.
   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      logic [DW-1:0] word_q;
      always_ff @(posedge clk) begin
         if (wr_en && (wr_idx == IW'(i))) begin
            word_q <= wr_data;
         end
      end
      assign words[i] = word_q;
   end

   assign rd_data = words[rd_idx];

endmodule

// File: rtl/lpq_window.sv
module lpq_window #(
   parameter int AW    = 16,
   parameter int DEPTH = 16,
   localparam int CW   = lpq_pkg::lpq_cnt_w(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ex_req,
   input  logic          ex_redir,
   input  logic [AW-1:0] ex_addr,
   input  logic          fill_ok,
   output logic          hit,
   output logic          flush,
   output logic [AW-1:0] fill_addr
);

   logic [AW-1:0] base_q;
   logic [CW-1:0] count_q;
   logic [AW-1:0] offset;
   logic          in_win;
   logic          full;

   assign offset    = ex_addr - base_q;
   assign in_win    = offset < AW'(count_q);
   assign full      = count_q == CW'(DEPTH);
   assign hit       = ex_req && in_win;
   assign flush     = ex_req && ex_redir && !in_win;
   assign fill_addr = base_q + AW'(count_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q  <= '0;
         count_q <= '0;
      end else if (flush) begin
         base_q  <= ex_addr;
         count_q <= '0;
      end else if (fill_ok) begin
         if (full) begin
            base_q <= base_q + AW'(1);
         end else begin
            count_q <= count_q + CW'(1);
         end
      end
   end

   AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= CW'(DEPTH));                                              // R9
   AST_PURGE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (count_q == '0) && (base_q == $past(ex_addr)));            // R7
   AST_FILL_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_ok && !full) |=> count_q == $past(count_q) + CW'(1));         // R3
   AST_FULL_SLIDES: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_ok && full) |=> full && (base_q == $past(base_q) + AW'(1)));   // R9

endmodule

// File: rtl/lpq_fetch.sv
module lpq_fetch #(
   parameter int AW    = 16,
   parameter int AHEAD = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          ex_req,
   input  logic [AW-1:0] ex_addr,
   input  logic [AW-1:0] fill_addr,
   input  logic          mem_gnt,
   input  logic          mem_rvalid,
   output logic          mem_req,
   output logic [AW-1:0] mem_addr,
   output logic          fill_ok,
   output logic          stale
);

   logic          busy_q;
   logic          tag_q;
   logic          epoch_q;
   logic [AW-1:0] pc_q;
   logic [AW-1:0] gap;
   logic          returning;

   assign gap       = fill_addr - pc_q;
   assign mem_req   = !busy_q && (gap < AW'(AHEAD));
   assign mem_addr  = fill_addr;
   assign returning = mem_rvalid && busy_q;
   assign fill_ok   = returning && (tag_q == epoch_q) && !flush;
   assign stale     = returning && ((tag_q != epoch_q) || flush);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         tag_q   <= 1'b0;
         epoch_q <= 1'b0;
         pc_q    <= '0;
      end else begin
         if (flush) begin
            epoch_q <= ~epoch_q;
         end
         if (ex_req) begin
            pc_q <= ex_addr;
         end
         if (mem_req && mem_gnt) begin
            busy_q <= 1'b1;
            tag_q  <= epoch_q;
         end else if (mem_rvalid) begin
            busy_q <= 1'b0;
         end
      end
   end

   AST_SINGLE_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_gnt) |=> !mem_req);                                  // R2
   AST_RETURN_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rvalid |-> busy_q);                                              // R2

endmodule

// File: rtl/insn_prefetch_queue.sv
module insn_prefetch_queue #(
   parameter int AW    = 16,
   parameter int DW    = 16,
   parameter int DEPTH = 16,
   parameter int AHEAD = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ex_req,
   input  logic          ex_redir,
   input  logic [AW-1:0] ex_addr,
   output logic [DW-1:0] ex_data,
   output logic          ex_valid,
   output logic          mem_req,
   output logic [AW-1:0] mem_addr,
   input  logic          mem_gnt,
   input  logic          mem_rvalid,
   input  logic [DW-1:0] mem_rdata
);

   localparam int IW = $clog2(DEPTH);
   localparam int CW = lpq_pkg::lpq_cnt_w(DEPTH);

   if (!lpq_pkg::lpq_pow2(DEPTH)) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if ((AHEAD < 1) || (AHEAD >= DEPTH)) begin : g_bad_ahead
      $error("AHEAD must lie in 1..DEPTH-1");
   end
   if (CW > AW) begin : g_bad_aw
      $error("address width too small for DEPTH");
   end

   logic          hit;
   logic          flush;
   logic          fill_ok;
   logic          stale;
   logic          bypass;
   logic [AW-1:0] fill_addr;
   logic [DW-1:0] rd_data;

   lpq_window #(.AW(AW), .DEPTH(DEPTH)) u_window (
      .clk       (clk),
      .rst_n     (rst_n),
      .ex_req    (ex_req),
      .ex_redir  (ex_redir),
      .ex_addr   (ex_addr),
      .fill_ok   (fill_ok),
      .hit       (hit),
      .flush     (flush),
      .fill_addr (fill_addr)
   );

   lpq_fetch #(.AW(AW), .AHEAD(AHEAD)) u_fetch (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .ex_req     (ex_req),
      .ex_addr    (ex_addr),
      .fill_addr  (fill_addr),
      .mem_gnt    (mem_gnt),
      .mem_rvalid (mem_rvalid),
      .mem_req    (mem_req),
      .mem_addr   (mem_addr),
      .fill_ok    (fill_ok),
      .stale      (stale)
   );

   lpq_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
      .clk     (clk),
      .wr_en   (fill_ok),
      .wr_idx  (fill_addr[IW-1:0]),
      .wr_data (mem_rdata),
      .rd_idx  (ex_addr[IW-1:0]),
      .rd_data (rd_data)
   );

   // A word arriving now is handed straight through when it is the one asked for.
   assign bypass   = ex_req && fill_ok && (fill_addr == ex_addr);
   assign ex_valid = hit || bypass;
   assign ex_data  = hit ? rd_data : mem_rdata;

   AST_VALID_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      ex_valid |-> ex_req);                                                // R10
   AST_STALE_NOT_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
      (stale && !hit) |-> !ex_valid);                                      // R8
   AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !hit);                                              // R1

endmodule

// File: tb/insn_prefetch_queue_tb.sv
module insn_prefetch_queue_tb_top;

   localparam int CLK_P = 10;
   localparam int AW    = 16;
   localparam int DW    = 16;
   localparam int AHEAD = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ex_req = 1'b0;
   logic          ex_redir = 1'b0;
   logic [AW-1:0] ex_addr = '0;
   logic [DW-1:0] ex_data;
   logic          ex_valid;
   logic          mem_req;
   logic [AW-1:0] mem_addr;
   logic          mem_gnt;
   logic          mem_rvalid;
   logic [DW-1:0] mem_rdata;

   int n_checks = 0;
   int n_fail = 0;
   int lat = 1;
   int cyc = 0;

   // memory model state
   logic          m_busy;
   int            m_cnt;
   logic [AW-1:0] m_paddr;
   int            g_cnt;
   logic [AW-1:0] g_last;

   always #(CLK_P/2) clk = ~clk;

   insn_prefetch_queue #(.AW(AW), .DW(DW), .DEPTH(16), .AHEAD(AHEAD)) dut_i (
      .clk(clk), .rst_n(rst_n), .ex_req(ex_req), .ex_redir(ex_redir),
      .ex_addr(ex_addr), .ex_data(ex_data), .ex_valid(ex_valid),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
   );

   function automatic logic [DW-1:0] word_of(input logic [AW-1:0] a);
      return (a * 16'd3) ^ 16'hA5C3;
   endfunction

   assign mem_gnt = mem_req && !m_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_busy     <= 1'b0;
         m_cnt      <= 0;
         m_paddr    <= '0;
         mem_rvalid <= 1'b0;
         mem_rdata  <= '0;
         g_cnt      <= 0;
         g_last     <= '0;
      end else begin
         mem_rvalid <= 1'b0;
         if (m_busy) begin
            if (m_cnt <= 1) begin
               mem_rvalid <= 1'b1;
               mem_rdata  <= word_of(m_paddr);
               m_busy     <= 1'b0;
            end else begin
               m_cnt <= m_cnt - 1;
            end
         end else if (mem_req && mem_gnt) begin
            m_busy  <= 1'b1;
            m_cnt   <= lat;
            m_paddr <= mem_addr;
            g_cnt   <= g_cnt + 1;
            g_last  <= mem_addr;
         end
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d (latency %0d)", req, act, exp, lat);
      end
   endtask

   task automatic summary;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
         summary();
         $finish;
      end
   end

   // Present one request; return the delivered word and the wait cycles.
   task automatic access(input logic [AW-1:0] a, input bit redir,
                         output logic [DW-1:0] d, output int waits);
      waits = 0;
      @(negedge clk);
      ex_req   = 1'b1;
      ex_addr  = a;
      ex_redir = redir;
      forever begin
         #1;
         if (ex_valid) begin
            d = ex_data;
            break;
         end
         if (waits > 100) begin
            d = '0;
            break;
         end
         waits++;
         @(negedge clk);
         ex_redir = 1'b0;
      end
   endtask

   task automatic idle(input int n);
      bit spurious = 1'b0;
      @(negedge clk);
      ex_req   = 1'b0;
      ex_redir = 1'b0;
      for (int i = 0; i < n; i++) begin
         #1;
         if (ex_valid) spurious = 1'b1;
         @(negedge clk);
      end
      check(!spurious, "R10 idle valid", int'(spurious), 0);
   endtask

   task automatic run_one;
      logic [DW-1:0] d;
      int w;
      int wsum;
      bit ok;
      int g0;

      rst_n = 1'b0;
      ex_req = 1'b0;
      ex_redir = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      check(mem_req == 1'b1 && mem_addr == 0, "R1 first fetch", int'(mem_addr), 0);
      check(ex_valid == 1'b0, "R1 reset valid", int'(ex_valid), 0);

      // sequential start from 0
      for (int a = 0; a < 8; a++) begin
         access(AW'(a), 1'b0, d, w);
         check(d == word_of(AW'(a)), "R3 sequential word", int'(d), int'(word_of(AW'(a))));
         if (a == 0) check(w > 0, "R10 miss waits", w, 1);
      end
      idle(20);
      check(g_cnt == 7 + AHEAD, "R4 fetch-ahead count", g_cnt, 7 + AHEAD);
      check(g_last == AW'(7 + AHEAD - 1), "R2 R4 last fetch address", int'(g_last), 7 + AHEAD - 1);

      // hit inside window
      access(16'd9, 1'b0, d, w);
      check(w == 0 && d == word_of(16'd9), "R5 hit same cycle", w, 0);
      idle(20);
      check(g_cnt == 9 + AHEAD, "R4 resume after advance", g_cnt, 9 + AHEAD);

      // tight loop inside window
      g0 = g_cnt;
      wsum = 0;
      ok = 1'b1;
      for (int it = 0; it < 2; it++) begin
         for (int a = 3; a <= 6; a++) begin
            access(AW'(a), a == 3, d, w);
            wsum += w;
            if (d != word_of(AW'(a))) ok = 1'b0;
         end
      end
      check(ok, "R6 loop data", int'(ok), 1);
      check(wsum == 0, "R6 loop waits", wsum, 0);
      check(g_cnt == g0, "R6 loop no fetch", g_cnt, g0);

      // run far enough to fill and slide the window
      ok = 1'b1;
      for (int a = 7; a <= 20; a++) begin
         access(AW'(a), 1'b0, d, w);
         if (d != word_of(AW'(a))) ok = 1'b0;
      end
      check(ok, "R3 long run data", int'(ok), 1);
      idle(30);
      check(g_cnt == 20 + AHEAD, "R4 long run count", g_cnt, 20 + AHEAD);
      access(16'd8, 1'b1, d, w);
      check(w == 0 && d == word_of(16'd8), "R9 oldest kept word hits", w, 0);
      access(16'd7, 1'b1, d, w);
      check(w > 0, "R9 dropped word misses", w, 1);
      check(d == word_of(16'd7), "R7 purge target data", int'(d), int'(word_of(16'd7)));
      check(g_last == 16'd7, "R7 refill from target", int'(g_last), 7);

      // redirect while the next sequential fetch is in flight
      g0 = g_cnt;
      access(16'd100, 1'b1, d, w);
      check(d == word_of(16'd100), "R8 stale return discarded", int'(d), int'(word_of(16'd100)));
      check(g_cnt == g0 + 2 && g_last == 16'd100, "R8 refetch target", int'(g_last), 100);
      access(16'd101, 1'b0, d, w);
      check(d == word_of(16'd101), "R3 after purge", int'(d), int'(word_of(16'd101)));
      idle(10);
   endtask

   initial begin
      for (int l = 1; l <= 3; l++) begin
         lat = l;
         run_one();
      end
      summary();
      $finish;
   end

endmodule